// File: doc/BRIEF.md
# Interrupt Redirection Register Window

This block holds the programmable state of a 24-input interrupt router and makes it reachable through a narrow, indirect register window. Software first writes a register selector at one bus offset. It then reads or writes the selected 32-bit register at a second offset. The selector can reach four kinds of register:

- an identifier register;
- a constant version register;
- an arbitration register that always reads zero;
- a table of 64-bit redirection entries, one per input, each reached as a low half and a high half.

The whole table is presented as a flat vector to the dispatch logic next to this block. A one-cycle strobe follows every attempted table write, so that the dispatch logic can rescan its pending inputs. Dispatch and message delivery are outside this block.

The bus port is single-cycle. A write takes effect at the clock edge on which it is presented. Read data is combinational from the address, the size and the current state. Each access carries a size: byte, halfword or word. A narrow write uses the low bits of the write data, zero-extended. A narrow read returns the low bits of the selected register.

Top module: `irq_route_regs`

## Requirements
- R1: Only bits 7:0 of the bus address are decoded. Offset 0x00 is the selector register and offset 0x10 is the data window. Any other offset reads zero, and a write to any other offset changes no state.
- R2: A write to offset 0x00 loads bits 7:0 of the write value into the selector. A read of offset 0x00 returns the selector zero-extended to 32 bits.
- R3: Selector 0x00 reads the 8-bit identifier in bits 31:24 and zero in bits 23:0. A window write with selector 0x00 loads the identifier from bits 31:24 of the write value. The identifier resets to the parameter ID_RESET.
- R4: Selector 0x01 reads 0x0017_0011: version 0x11 in bits 7:0 and the highest entry index, 23, in bits 23:16. Selector 0x02 reads zero. Window writes with either selector change nothing.
- R5: A selector s with 0x10 <= s <= 0x3F reaches entry (s-0x10)/2. An even s reaches bits 31:0 of that entry, and an odd s reaches bits 63:32. A write to a high half is always accepted.
- R6: A write to a low half is accepted only if bit 16 (mask) of the write value is 1, or its bits 7:0 lie in 0x10..0xFE. Otherwise the entry keeps its previous value.
- R7: Reset clears the selector to 0 and sets every entry to 0x0000_0000_0001_0000, so every input starts masked.
- R8: The strobe tbl_wr_o is high for exactly the one cycle after a window write whose selector reaches an entry, whether the write was accepted or dropped. In all other cycles it is low.
- R9: A selector of 0x40 or above reads zero at the window. A window write with such a selector changes no state and raises no strobe.
- R10: bus_size 0 is a byte access, 1 is a halfword access, and 2 or 3 is a word access. A write uses the write data masked to the access width. A read returns the selected 32-bit value masked to the access width.
- R11: Bits 64k+63 down to 64k of tbl_o always equal entry k, and a write becomes visible there in the cycle after its clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| bus_addr | input | ADDR_W (12) | Byte address; only bits 7:0 decoded |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the presented address and size |
| tbl_o | output | N_ENTRIES*64 (1536) | Flat redirection table, entry k at bits 64k+63:64k |
| tbl_wr_o | output | 1 | One-cycle pulse after an attempted table write |

## Verification
The embedded assertions check several properties on every cycle:

- the strobe follows exactly the cycles that carried an attempted entry write;
- a selector write lands on the next edge;
- at most one half-entry write enable is active at a time;
- a rejected low-half write leaves its entry stable;
- a high-half write is taken as written;
- the version read holds its constant value.

Other behaviours need the bench's reference model and directed scenarios to show them. These include:

- the legal vector boundaries at 0x0F, 0x10, 0xFE and 0xFF, with the mask bit overriding them;
- aliasing of offsets above 0xFF;
- the selectors just past the last entry;
- narrow accesses;
- the parameterized identifier reset value;
- state being restored by a second reset taken in the middle of a run.

// File: rtl/irw_pkg.sv
package irw_pkg;

  localparam logic [7:0] OFS_SELECT  = 8'h00;
  localparam logic [7:0] OFS_WINDOW  = 8'h10;
  localparam logic [7:0] SEL_IDENT   = 8'h00;
  localparam logic [7:0] SEL_VERSION = 8'h01;
  localparam logic [7:0] SEL_TBASE   = 8'h10;
  localparam logic [7:0] VEC_LOW     = 8'h10;
  localparam logic [7:0] VEC_HIGH    = 8'hFE;
  localparam int unsigned MASK_POS   = 16;

  typedef enum logic [1:0] {
    ACC_BYTE  = 2'd0,
    ACC_HALF  = 2'd1,
    ACC_WORD  = 2'd2,
    ACC_WORD3 = 2'd3
  } acc_size_e;

  // Lane mask for an access of the given width.
  function automatic logic [31:0] lane_mask(acc_size_e sz);
    case (sz)
      ACC_BYTE: return 32'h0000_00FF;
      ACC_HALF: return 32'h0000_FFFF;
      default:  return 32'hFFFF_FFFF;
    endcase
  endfunction

  // A low-half value may be stored when masked or carrying a usable vector.
  function automatic logic low_half_ok(logic [31:0] v);
    return v[MASK_POS] || ((v[7:0] >= VEC_LOW) && (v[7:0] <= VEC_HIGH));
  endfunction

  // Entry number reached by a selector at or above the table base.
  function automatic logic [6:0] sel_entry(logic [7:0] sel);
    logic [7:0] d;
    d = sel - SEL_TBASE;
    return d[7:1];
  endfunction

  function automatic logic sel_hits_table(logic [7:0] sel, int unsigned n);
    return (sel >= SEL_TBASE) && (32'(sel_entry(sel)) < n);
  endfunction

endpackage

// File: rtl/irw_decode.sv
module irw_decode
  import irw_pkg::*;
#(
  parameter int unsigned N_ENTRIES = 24
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_valid,
  input  logic                 bus_write,
  input  acc_size_e            acc_size,
  input  logic [7:0]           ofs,
  input  logic [31:0]          wdata,
  input  logic [7:0]           sel,
  output logic [31:0]          wval,
  output logic                 sel_we,
  output logic                 id_we,
  output logic                 tbl_touch,
  output logic [N_ENTRIES-1:0] lo_we,
  output logic [N_ENTRIES-1:0] hi_we
);

  logic       wr_req;
  logic       win_wr;
  logic [6:0] idx;

  always_comb begin
    wval      = wdata & lane_mask(acc_size);
    wr_req    = bus_valid && bus_write;
    sel_we    = wr_req && (ofs == OFS_SELECT);
    win_wr    = wr_req && (ofs == OFS_WINDOW);
    id_we     = win_wr && (sel == SEL_IDENT);
    tbl_touch = win_wr && sel_hits_table(sel, N_ENTRIES);
    idx       = sel_entry(sel);
  end

  for (genvar k = 0; k < N_ENTRIES; k++) begin : g_we
    assign lo_we[k] = tbl_touch && (idx == 7'(k)) && !sel[0];
    assign hi_we[k] = tbl_touch && (idx == 7'(k)) &&  sel[0];
  end

  // R5: a selector reaches at most one half of one entry
  p_single_half_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0({lo_we, hi_we}));

endmodule

// File: rtl/irw_entry.sv
module irw_entry
  import irw_pkg::*;
#(
  parameter logic [63:0] RESET_VAL = 64'h0000_0000_0001_0000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        lo_we,
  input  logic        hi_we,
  input  logic [31:0] wval,
  output logic [63:0] q
);

  logic lo_take;
  assign lo_take = lo_we && low_half_ok(wval);

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= RESET_VAL;
    end else begin
      if (lo_take) q[31:0]  <= wval;
      if (hi_we)   q[63:32] <= wval;
    end
  end

  // R6: an unmasked write with a vector outside the legal band is dropped
  p_drop_bad_vector_r6: assert property (@(posedge clk) disable iff (rst)
    (lo_we && !wval[MASK_POS] && ((wval[7:0] < VEC_LOW) || (wval[7:0] == 8'hFF)))
    |=> $stable(q));

  // R5: high-half writes are stored as written
  p_high_store_r5: assert property (@(posedge clk) disable iff (rst)
    hi_we |=> (q[63:32] == $past(wval)));

endmodule

// File: rtl/irw_rdmux.sv
module irw_rdmux
  import irw_pkg::*;
#(
  parameter int unsigned N_ENTRIES = 24,
  parameter logic [7:0]  VERSION   = 8'h11
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [7:0]             ofs,
  input  acc_size_e              acc_size,
  input  logic [7:0]             sel,
  input  logic [7:0]             ident,
  input  logic [N_ENTRIES*64-1:0] tbl,
  output logic [31:0]            rdata
);

  localparam logic [7:0]  TOP_IDX  = 8'(N_ENTRIES - 1);
  localparam logic [31:0] VER_WORD = {8'h00, TOP_IDX, 8'h00, VERSION};

  function automatic logic [31:0] window_word(logic [7:0] s, logic [7:0] id,
                                              logic [N_ENTRIES*64-1:0] t);
    logic [63:0] ent;
    if (s == SEL_IDENT)        return {id, 24'h0};
    if (s == SEL_VERSION)      return VER_WORD;
    if (!sel_hits_table(s, N_ENTRIES)) return 32'h0;
    ent = t[32'(sel_entry(s))*64 +: 64];
    return s[0] ? ent[63:32] : ent[31:0];
  endfunction

  logic [31:0] raw;

  always_comb begin
    if (ofs == OFS_SELECT)      raw = {24'h0, sel};
    else if (ofs == OFS_WINDOW) raw = window_word(sel, ident, tbl);
    else                        raw = 32'h0;
    rdata = raw & lane_mask(acc_size);
  end

  // R4: the version register is constant at the window
  p_version_const_r4: assert property (@(posedge clk) disable iff (rst)
    (ofs == OFS_WINDOW && sel == SEL_VERSION && acc_size == ACC_WORD)
    |-> (rdata == VER_WORD));

endmodule

// File: rtl/irq_route_regs.sv
module irq_route_regs
  import irw_pkg::*;
#(
  parameter int unsigned N_ENTRIES = 24,
  parameter int unsigned ADDR_W    = 12,
  parameter logic [7:0]  ID_RESET  = 8'h00,
  parameter logic [7:0]  VERSION   = 8'h11
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    bus_valid,
  input  logic                    bus_write,
  input  logic [1:0]              bus_size,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic [31:0]             bus_wdata,
  output logic [31:0]             bus_rdata,
  output logic [N_ENTRIES*64-1:0] tbl_o,
  output logic                    tbl_wr_o
);

  localparam logic [63:0] ENTRY_RST = 64'h1 << MASK_POS;

  logic [7:0]           ofs;
  logic                 unused_hi_addr;
  acc_size_e            acc_size;
  logic [31:0]          wval;
  logic                 sel_we, id_we, tbl_touch;
  logic [N_ENTRIES-1:0] lo_we, hi_we;
  logic [7:0]           sel_q;
  logic [7:0]           id_q;
  logic                 strobe_q;

  assign ofs            = bus_addr[7:0];
  assign unused_hi_addr = ^bus_addr;
  assign acc_size       = acc_size_e'(bus_size);

  irw_decode #(.N_ENTRIES(N_ENTRIES)) u_decode (
    .clk(clk), .rst(rst),
    .bus_valid(bus_valid), .bus_write(bus_write), .acc_size(acc_size),
    .ofs(ofs), .wdata(bus_wdata), .sel(sel_q),
    .wval(wval), .sel_we(sel_we), .id_we(id_we), .tbl_touch(tbl_touch),
    .lo_we(lo_we), .hi_we(hi_we)
  );

  for (genvar k = 0; k < N_ENTRIES; k++) begin : g_entry
    irw_entry #(.RESET_VAL(ENTRY_RST)) u_entry (
      .clk(clk), .rst(rst),
      .lo_we(lo_we[k]), .hi_we(hi_we[k]), .wval(wval),
      .q(tbl_o[k*64 +: 64])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q    <= 8'h00;
      id_q     <= ID_RESET;
      strobe_q <= 1'b0;
    end else begin
      if (sel_we) sel_q <= wval[7:0];
      if (id_we)  id_q  <= wval[31:24];
      strobe_q <= tbl_touch;
    end
  end

  assign tbl_wr_o = strobe_q;

  irw_rdmux #(.N_ENTRIES(N_ENTRIES), .VERSION(VERSION)) u_rdmux (
    .clk(clk), .rst(rst),
    .ofs(ofs), .acc_size(acc_size), .sel(sel_q), .ident(id_q),
    .tbl(tbl_o), .rdata(bus_rdata)
  );

  // R2: a selector write is visible on the next cycle
  p_sel_load_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && bus_write && ofs == OFS_SELECT)
    |=> (sel_q == $past(bus_wdata[7:0] & lane_mask(acc_size)[7:0])));

  // R8: an attempted entry write raises the strobe for the following cycle
  p_strobe_after_touch_r8: assert property (@(posedge clk) disable iff (rst)
    tbl_touch |=> tbl_wr_o);

  // R8: no strobe without an entry write
  p_strobe_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !tbl_touch |=> !tbl_wr_o);

endmodule

// File: tb/irq_route_regs_bench.sv
module irq_route_regs_bench;

  localparam int          N   = 24;
  localparam logic [7:0]  IDR = 8'hA5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bvalid = 1'b0, bwrite = 1'b0;
  logic [1:0]    bsize = 2'd2;
  logic [11:0]   baddr = '0;
  logic [31:0]   bwdata = '0;
  logic [31:0]   rdata;
  logic [N*64-1:0] tbl;
  logic          tstrobe;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  irq_route_regs #(.N_ENTRIES(N), .ADDR_W(12), .ID_RESET(IDR)) u_irq_route_regs (
    .clk(clk), .rst(rst), .bus_valid(bvalid), .bus_write(bwrite),
    .bus_size(bsize), .bus_addr(baddr), .bus_wdata(bwdata),
    .bus_rdata(rdata), .tbl_o(tbl), .tbl_wr_o(tstrobe)
  );

  // ---------------- behavioural reference model ----------------
  logic [63:0] m_tbl [N];
  int          m_sel;
  int          m_id;
  bit          m_strobe;

  function automatic int size_keep(input logic [1:0] sz, input logic [31:0] v);
    if (sz == 2'd0) return int'(v % 256);
    if (sz == 2'd1) return int'(v % 65536);
    return int'(v);
  endfunction

  function automatic logic [31:0] model_read(input logic [11:0] a, input logic [1:0] sz);
    int o;
    logic [31:0] r;
    o = int'(a) % 256;
    r = 0;
    if (o == 0) r = m_sel;
    else if (o == 16) begin
      if (m_sel == 0) r = m_id * 32'h0100_0000;
      else if (m_sel == 1) r = ((N - 1) * 65536) + 17;
      else if (m_sel >= 16 && (m_sel - 16) / 2 < N) begin
        if (m_sel % 2 == 1) r = m_tbl[(m_sel - 16) / 2][63:32];
        else                r = m_tbl[(m_sel - 16) / 2][31:0];
      end
    end
    return size_keep(sz, r);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < N; k++) m_tbl[k] = 64'd65536;
      m_sel = 0; m_id = IDR; m_strobe = 0;
    end else begin
      bit touch;
      logic [31:0] v;
      int o;
      touch = 0;
      v = size_keep(bsize, bwdata);
      o = int'(baddr) % 256;
      if (bvalid && bwrite) begin
        if (o == 0) m_sel = v % 256;
        else if (o == 16) begin
          if (m_sel == 0) m_id = v / 32'h0100_0000;
          else if (m_sel >= 16 && (m_sel - 16) / 2 < N) begin
            touch = 1;
            if (m_sel % 2 == 1) m_tbl[(m_sel - 16) / 2][63:32] = v;
            else if (v[16] || (v % 256 >= 16 && v % 256 <= 254))
              m_tbl[(m_sel - 16) / 2][31:0] = v;
          end
        end
      end
      m_strobe = touch;
    end
  end

  task automatic check(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string read_tag(input logic [11:0] a);
    int o;
    o = int'(a) % 256;
    if (o != 0 && o != 16) return "R1";
    if (o == 0) return "R2";
    if (m_sel == 0) return "R3";
    if (m_sel < 16) return "R4";
    if ((m_sel - 16) / 2 < N) return "R5";
    return "R9";
  endfunction

  // per-cycle comparison against the model, away from the clock edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      #2;
      check(rdata == model_read(baddr, bsize), read_tag(baddr), rdata, model_read(baddr, bsize));
      check(tstrobe == m_strobe, "R8", tstrobe, m_strobe);
      for (int k = 0; k < N; k++)
        if (tbl[k*64 +: 64] !== m_tbl[k])
          check(0, "R11", tbl[k*64 +: 64], m_tbl[k]);
      checks++;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic bus_wr(input logic [11:0] a, input logic [31:0] d, input logic [1:0] sz = 2'd2);
    @(negedge clk);
    bvalid = 1; bwrite = 1; baddr = a; bwdata = d; bsize = sz;
    @(negedge clk);
    bvalid = 0; bwrite = 0; bsize = 2'd2;
  endtask

  task automatic bus_rd(input logic [11:0] a, input logic [1:0] sz,
                        input logic [31:0] exp, input string tag);
    @(negedge clk);
    bvalid = 1; bwrite = 0; baddr = a; bsize = sz;
    #3;
    check(rdata == exp, tag, rdata, exp);
  endtask

  task automatic strobe_is(input bit exp, input string tag);
    #3;
    check(tstrobe == exp, tag, tstrobe, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 0;

    // reset state
    bus_rd(12'h000, 2'd2, 32'h0, "R7");
    bus_rd(12'h010, 2'd2, 32'hA500_0000, "R3");

    // version and arbitration registers
    bus_wr(12'h000, 32'h1);
    bus_rd(12'h010, 2'd2, 32'h0017_0011, "R4");
    bus_wr(12'h010, 32'hFFFF_FFFF);
    strobe_is(0, "R8");
    bus_rd(12'h010, 2'd2, 32'h0017_0011, "R4");
    bus_wr(12'h000, 32'h2);
    bus_rd(12'h010, 2'd2, 32'h0, "R4");

    // entry 0 low half: vector filter
    bus_wr(12'h000, 32'h10);
    bus_rd(12'h010, 2'd2, 32'h0001_0000, "R7");
    bus_wr(12'h010, 32'h0000_0005);
    strobe_is(1, "R8");
    bus_rd(12'h010, 2'd2, 32'h0001_0000, "R6");
    bus_wr(12'h010, 32'h0000_000F);
    bus_rd(12'h010, 2'd2, 32'h0001_0000, "R6");
    bus_wr(12'h010, 32'h0000_0010);
    bus_rd(12'h010, 2'd2, 32'h0000_0010, "R6");
    bus_wr(12'h010, 32'h0000_00FF);
    bus_rd(12'h010, 2'd2, 32'h0000_0010, "R6");
    bus_wr(12'h010, 32'h0001_00FF);
    bus_rd(12'h010, 2'd2, 32'h0001_00FF, "R6");
    bus_wr(12'h010, 32'h0000_00FE);
    bus_rd(12'h010, 2'd2, 32'h0000_00FE, "R6");

    // high half of entry 0
    bus_wr(12'h000, 32'h11);
    bus_wr(12'h010, 32'hAB00_0000);
    bus_rd(12'h010, 2'd2, 32'hAB00_0000, "R5");
    check(tbl[63:0] == 64'hAB00_0000_0000_00FE, "R11", tbl[63:0], 64'hAB00_0000_0000_00FE);

    // last entry
    bus_wr(12'h000, 32'h3F);
    bus_wr(12'h010, 32'h1234_5678);
    bus_rd(12'h010, 2'd2, 32'h1234_5678, "R5");
    check(tbl[23*64+32 +: 32] == 32'h1234_5678, "R11", tbl[23*64+32 +: 32], 32'h1234_5678);
    bus_wr(12'h000, 32'h3E);
    bus_rd(12'h010, 2'd2, 32'h0001_0000, "R7");

    // beyond the table
    bus_wr(12'h000, 32'h40);
    bus_wr(12'h010, 32'h0000_0011);
    strobe_is(0, "R9");
    bus_rd(12'h010, 2'd2, 32'h0, "R9");

    // identifier write
    bus_wr(12'h000, 32'h0);
    bus_wr(12'h010, 32'h5A00_1234);
    bus_rd(12'h010, 2'd2, 32'h5A00_0000, "R3");

    // address decode
    bus_rd(12'h004, 2'd2, 32'h0, "R1");
    bus_rd(12'h110, 2'd2, 32'h5A00_0000, "R1");
    bus_wr(12'h020, 32'h7700_0000);
    bus_rd(12'h010, 2'd2, 32'h5A00_0000, "R1");
    bus_wr(12'h100, 32'h11);
    bus_rd(12'h000, 2'd2, 32'h11, "R2");

    // narrow accesses
    bus_wr(12'h000, 32'hFFFF_FF12, 2'd0);
    bus_rd(12'h000, 2'd2, 32'h12, "R10");
    bus_wr(12'h010, 32'hFFFF_0040, 2'd1);
    bus_rd(12'h010, 2'd2, 32'h0000_0040, "R10");
    bus_wr(12'h000, 32'h1);
    bus_rd(12'h010, 2'd1, 32'h0000_0011, "R10");
    bus_rd(12'h010, 2'd0, 32'h0000_0011, "R10");

    // randomised traffic compared against the model every cycle
    for (int i = 0; i < 800; i++) begin
      int pick;
      logic [31:0] d;
      logic [11:0] a;
      pick = int'($urandom % 8);
      d = $urandom;
      if (pick < 3) begin
        d = (pick == 0) ? ($urandom % 72) : ($urandom % 256);
        bus_wr(12'h000, d, 2'($urandom % 4));
      end else if (pick < 6) begin
        if ($urandom % 2 == 0) d[16] = 1'b0;
        if ($urandom % 3 == 0) d[7:0] = 8'($urandom % 20);
        bus_wr(12'h010 | ((($urandom % 2) == 0) ? 12'h0 : 12'h300), d, 2'($urandom % 4));
      end else begin
        a = ($urandom % 3 == 0) ? 12'($urandom) : (($urandom % 2 == 0) ? 12'h010 : 12'h000);
        @(negedge clk);
        bvalid = 1; bwrite = 0; baddr = a; bsize = 2'($urandom % 4);
      end
      if (i == 400) begin
        @(negedge clk); rst = 1;
        @(negedge clk); rst = 0;
        bus_wr(12'h000, 32'h1A);
        bus_rd(12'h010, 2'd2, 32'h0001_0000, "R7");
      end
    end

    @(negedge clk); bvalid = 0;
    repeat (2) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule